// File: doc/BRIEF.md
# Sleep Power Sequencer

This block steps a chip into and out of a low-power sleep state. All sequencing runs on a slow timebase: the fast system clock samples a one-cycle `tick` strobe, nominally once per 32.768 kHz period, about 30.5 µs. The block changes state only on those ticks. When the chip asks to sleep, the block first drives the active-low reset output low. Two ticks later it removes power-enable and then waits in sleep.

While asleep, the block watches sixteen wake pins. A mask selects which pins can wake it. A pin is accepted only if it stays high for three consecutive ticks. A low battery-fault input stops all wake qualification. When a pin qualifies, the block raises power-enable and records which pins caused the wake. It then holds reset for a settle period while the supply comes up. The period ends after 328 ticks (about 10 ms), or earlier when the supply reports good and no supply fault is flagged. Reset is then released and the block returns to run.

Top module: `sleep_seq`

## Requirements
- R1: Out of reset the block is in run: `resetOutN`=1, `pwrEn`=1, `wakeStatus`=0.
- R2: A high `sleepReq` seen on a tick drives `resetOutN` low on that tick. `pwrEn` falls exactly two ticks later. One tick after that, the block is in sleep.
- R3: No output or state changes on a clock edge where `tick` is low.
- R4: Wake pin i takes part only while bit i of `wakeMask` is 1. An unmasked pin never ends sleep.
- R5: A wake pin must be high at three consecutive ticks, counting the first tick it is seen high in sleep. `pwrEn` rises on the third of those ticks. A pulse that drops earlier returns the block to sleep with its count cleared.
- R6: While `battFaultN` is 0, wake pins are ignored and partial qualification is cleared.
- R7: From the rise of `pwrEn`, `resetOutN` stays low through the settle period. The settle wait begins on the next tick. It may end early on a tick when `supplyGood`=1 and `vddFaultN`=1, but no earlier than the second tick after it begins.
- R8: If the supply never reports good, `resetOutN` rises on the 328th tick after the settle wait begins.
- R9: While `vddFaultN` is 0, `supplyGood` cannot end the settle wait early.
- R10: On the tick where the block wakes, `wakeStatus` records every pin that qualifies on that tick (bit i is pin i). The value holds until the next sleep request clears it.
- R11: One tick after reset is released, the block is back in run and accepts a new sleep request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow-timebase strobe |
| sleepReq | input | 1 | Internal request to enter sleep |
| wakePins | input | 16 | Wake pin levels |
| wakeMask | input | 16 | Per-pin wake enables |
| battFaultN | input | 1 | Battery fault, active low; low blocks wake |
| vddFaultN | input | 1 | Supply fault, active low; low blocks early settle exit |
| supplyGood | input | 1 | Supply reports stable |
| resetOutN | output | 1 | Active-low reset to the rest of the chip |
| pwrEn | output | 1 | Enable for the core supply |
| wakeStatus | output | 16 | Pins that caused the last wake |

## Verification
The assertions take three things for granted. `tick` is a single-cycle pulse. `wakeMask` holds steady from the sleep request until the wake completes. Every input is synchronous to `clk`. The stimulus drives all inputs on the falling clock edge and pulses `tick` for exactly one cycle at a time. It changes the mask only while the block is in run. Pin, battery and supply inputs change only between ticks. This lets each check sample at a known tick boundary.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER_RST, ST_PWR_OFF, ST_SLEEP,
    ST_WAKE_QUAL, ST_PWR_ON, ST_VCC_WAIT, ST_RELEASE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic qualTick;    // advance per-pin hold counters
    logic qualClr;     // clear per-pin hold counters
    logic latchStatus; // capture qualifying pins
    logic clrStatus;   // clear captured pins
    logic settleTick;  // advance settle counter
    logic settleClr;   // clear settle counter
  } seqStrobe_t;

endpackage

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int NUM_PINS     = 16,
  parameter int QUAL_TICKS   = 3,
  parameter int SETTLE_TICKS = 328
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobes,
  input  logic [NUM_PINS-1:0] wakePins,
  input  logic [NUM_PINS-1:0] wakeMask,
  input  logic                battFaultN,
  input  logic                vddFaultN,
  input  logic                supplyGood,
  output logic                anyActive,
  output logic                anyQualified,
  output logic                settleDone,
  output logic                earlyOk,
  output logic [NUM_PINS-1:0] wakeStatus
);

  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int SW = $clog2(SETTLE_TICKS);
  localparam logic [QW-1:0] QUAL_LAST  = QW'(QUAL_TICKS - 1);
  localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_TICKS - 1);

  logic [NUM_PINS-1:0] pinActive;
  logic [NUM_PINS-1:0] pinQualified;
  logic [SW-1:0]       settleCnt;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
      logic [QW-1:0] holdCnt;
      assign pinActive[i]    = wakePins[i] & wakeMask[i] & battFaultN;
      assign pinQualified[i] = pinActive[i] && (holdCnt >= QUAL_LAST);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdCnt <= '0;
        end else if (strobes.qualClr) begin
          holdCnt <= '0;
        end else if (strobes.qualTick) begin
          if (!pinActive[i])                     holdCnt <= '0;
          else if (holdCnt < QW'(QUAL_TICKS))    holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  endgenerate

  assign anyActive    = |pinActive;
  assign anyQualified = |pinQualified;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeStatus <= '0;
    end else if (strobes.clrStatus) begin
      wakeStatus <= '0;
    end else if (strobes.latchStatus) begin
      wakeStatus <= pinQualified;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobes.settleClr) begin
      settleCnt <= '0;
    end else if (strobes.settleTick && settleCnt != SETTLE_END) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign settleDone = (settleCnt == SETTLE_END);
  assign earlyOk    = (settleCnt != '0) && supplyGood && vddFaultN;

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt < SW'(SETTLE_TICKS)) else $error("settle counter overran"); // R8

  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchStatus |=> ((wakeStatus & ~$past(wakeMask)) == '0))
    else $error("unmasked pin recorded"); // R4

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int ENTER_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       sleepReq,
  input  logic       battFaultN,
  input  logic       anyActive,
  input  logic       anyQualified,
  input  logic       settleDone,
  input  logic       earlyOk,
  output seqStrobe_t strobes,
  output logic       resetOutN,
  output logic       pwrEn
);

  localparam int EW = $clog2(ENTER_TICKS + 1);
  localparam logic [EW-1:0] ENTER_LAST = EW'(ENTER_TICKS - 1);

  seqState_e state, nextState;
  logic [EW-1:0] enterCnt;
  logic inQual;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:       if (sleepReq)                  nextState = ST_ENTER_RST;
      ST_ENTER_RST: if (enterCnt == ENTER_LAST)    nextState = ST_PWR_OFF;
      ST_PWR_OFF:                                  nextState = ST_SLEEP;
      ST_SLEEP:     if (battFaultN && anyActive)   nextState = ST_WAKE_QUAL;
      ST_WAKE_QUAL: begin
        if (!battFaultN || !anyActive)             nextState = ST_SLEEP;
        else if (anyQualified)                     nextState = ST_PWR_ON;
      end
      ST_PWR_ON:                                   nextState = ST_VCC_WAIT;
      ST_VCC_WAIT:  if (settleDone || earlyOk)     nextState = ST_RELEASE;
      ST_RELEASE:                                  nextState = ST_RUN;
      default:                                     nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else if (tick) begin
      state <= nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enterCnt <= '0;
    end else if (state != ST_ENTER_RST) begin
      enterCnt <= '0;
    end else if (tick && enterCnt != ENTER_LAST) begin
      enterCnt <= enterCnt + 1'b1;
    end
  end

  assign inQual = (state == ST_SLEEP) || (state == ST_WAKE_QUAL);

  always_comb begin
    strobes             = '0;
    strobes.qualTick    = tick && inQual;
    strobes.qualClr     = !inQual;
    strobes.latchStatus = tick && (state == ST_WAKE_QUAL) && (nextState == ST_PWR_ON);
    strobes.clrStatus   = tick && (state == ST_RUN) && (nextState == ST_ENTER_RST);
    strobes.settleTick  = tick && (state == ST_VCC_WAIT);
    strobes.settleClr   = (state != ST_VCC_WAIT);
  end

  assign resetOutN = (state == ST_RUN) || (state == ST_RELEASE);
  assign pwrEn     = !((state == ST_PWR_OFF) || (state == ST_SLEEP) ||
                       (state == ST_WAKE_QUAL));

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(state)) else $error("state moved without tick"); // R3

  AST_PWR_OFF_UNDER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> !resetOutN) else $error("power dropped with reset released"); // R2

  AST_WAKE_BATT_OK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrEn) |-> $past(battFaultN)) else $error("woke during battery fault"); // R6

  AST_RELEASE_WITH_PWR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOutN) |-> pwrEn) else $error("reset released without power"); // R7

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int NUM_PINS     = 16,
  parameter int ENTER_TICKS  = 2,
  parameter int QUAL_TICKS   = 3,
  parameter int SETTLE_TICKS = 328
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                sleepReq,
  input  logic [NUM_PINS-1:0] wakePins,
  input  logic [NUM_PINS-1:0] wakeMask,
  input  logic                battFaultN,
  input  logic                vddFaultN,
  input  logic                supplyGood,
  output logic                resetOutN,
  output logic                pwrEn,
  output logic [NUM_PINS-1:0] wakeStatus
);

  seqStrobe_t strobes;
  logic anyActive, anyQualified, settleDone, earlyOk;

  sleep_seq_ctrl #(.ENTER_TICKS(ENTER_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .sleepReq(sleepReq),
    .battFaultN(battFaultN), .anyActive(anyActive),
    .anyQualified(anyQualified), .settleDone(settleDone), .earlyOk(earlyOk),
    .strobes(strobes), .resetOutN(resetOutN), .pwrEn(pwrEn)
  );

  sleep_seq_dp #(
    .NUM_PINS(NUM_PINS), .QUAL_TICKS(QUAL_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wakePins(wakePins),
    .wakeMask(wakeMask), .battFaultN(battFaultN), .vddFaultN(vddFaultN),
    .supplyGood(supplyGood), .anyActive(anyActive),
    .anyQualified(anyQualified), .settleDone(settleDone), .earlyOk(earlyOk),
    .wakeStatus(wakeStatus)
  );

endmodule

// File: tb/tb_sleep_seq.sv
module tb_sleep_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic sleepReq = 1'b0;
  logic [15:0] wakePins = '0;
  logic [15:0] wakeMask = '0;
  logic battFaultN = 1'b1;
  logic vddFaultN = 1'b1;
  logic supplyGood = 1'b0;
  logic resetOutN, pwrEn;
  logic [15:0] wakeStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_seq dut (
    .clk(clk), .rstN(rstN), .tick(tick), .sleepReq(sleepReq),
    .wakePins(wakePins), .wakeMask(wakeMask), .battFaultN(battFaultN),
    .vddFaultN(vddFaultN), .supplyGood(supplyGood),
    .resetOutN(resetOutN), .pwrEn(pwrEn), .wakeStatus(wakeStatus)
  );

  // row: {sleepReq, wakePins, battFaultN, supplyGood, expResetOutN, expPwrEn}
  localparam logic [20:0] VEC [0:15] = '{
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R11 run holds
    {1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 reset first
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 power kept one more tick
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 power off two ticks later
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 asleep
    {1'b0, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 unmasked pin
    {1'b0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 battery fault
    {1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 pin0 count 1
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 short pulse dropped
    {1'b0, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 pin2 count 1
    {1'b0, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 pin2 count 2
    {1'b0, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 qualified, power on
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 settle begins
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 too early to exit
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 early release
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}  // R11 back in run
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wakeMask = 16'h0005;
    repeat (3) @(negedge clk);
    check({14'd0, resetOutN, pwrEn}, 16'h0003, "R1 outputs in reset");
    rstN = 1'b1;
    @(negedge clk);
    check({14'd0, resetOutN, pwrEn}, 16'h0003, "R1 outputs after reset");
    check(wakeStatus, 16'h0000, "R1 status after reset");

    // R3: request without tick does nothing
    sleepReq = 1'b1;
    repeat (5) @(negedge clk);
    check({15'd0, resetOutN}, 16'h0001, "R3 no tick no change");
    sleepReq = 1'b0;

    for (int i = 0; i < 16; i++) begin
      sleepReq   = VEC[i][20];
      wakePins   = VEC[i][19:4];
      battFaultN = VEC[i][3];
      supplyGood = VEC[i][2];
      tickOnce();
      check({14'd0, resetOutN, pwrEn}, {14'd0, VEC[i][1:0]},
            $sformatf("R2 R4 R5 R6 R7 R11 row %0d", i));
    end
    sleepReq = 1'b0; wakePins = '0; supplyGood = 1'b0;
    check(wakeStatus, 16'h0004, "R10 waking pin recorded");

    // second cycle: simultaneous pins, supply fault, timeout
    sleepReq = 1'b1;
    tickOnce();
    sleepReq = 1'b0;
    check(wakeStatus, 16'h0000, "R10 cleared on sleep request");
    tickOnce(); tickOnce();
    check({15'd0, pwrEn}, 16'h0000, "R2 power off second cycle");
    tickOnce();
    wakePins = 16'h0007;
    tickOnce(); tickOnce();
    check({15'd0, pwrEn}, 16'h0000, "R5 not yet qualified");
    tickOnce();
    check({15'd0, pwrEn}, 16'h0001, "R5 power on third tick");
    check(wakeStatus, 16'h0005, "R10 both masked pins recorded");
    wakePins = '0;
    vddFaultN = 1'b0;
    supplyGood = 1'b1;
    tickOnce(); // settle begins
    for (int k = 1; k < 328; k++) begin
      tickOnce();
      if (k == 5 || k == 327)
        check({15'd0, resetOutN}, 16'h0000, "R9 fault blocks early exit");
    end
    tickOnce();
    check({14'd0, resetOutN, pwrEn}, 16'h0003, "R8 release at tick 328");
    vddFaultN = 1'b1; supplyGood = 1'b0;
    tickOnce();
    sleepReq = 1'b1;
    tickOnce();
    sleepReq = 1'b0;
    check({15'd0, resetOutN}, 16'h0000, "R11 new sleep accepted");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule